// File: doc/BRIEF.md
# Two-Pulse Clutter Canceller for Range-Bin Streams

This block sits in a radar receive chain after range decimation and before the Doppler stage. It receives one complex sample per range bin for each chirp. For every sample it subtracts the sample that arrived at the same range bin during the previous chirp. The result is the first difference across chirps, 1 - z^-1 in slow time. Echoes from stationary objects repeat unchanged from chirp to chirp, so this difference suppresses them. The previous chirp is kept in an internal history memory with one entry per range bin.

A host-controlled enable chooses between cancelling and exact pass-through. It comes out of reset disabled. The enable is sampled only on the first sample of a chirp, so a chirp is never processed half one way and half the other. The first chirp processed with the canceller on has no valid history, so its samples come out as zero. Differences come out one bit wider than the input, so they can never overflow. In pass-through the input is sign-extended to that width.

Top module: `mti_canceller`

## Requirements
- R1: After reset `out_valid` is 0, the data and bin outputs are 0, and the enable state is off. Samples that arrive before the first start-of-chirp pass through unchanged, whatever `cancel_en` is.
- R2: While the captured enable is 0, each valid sample leaves as `out_i`/`out_q` equal to `in_i`/`in_q` sign-extended to DW+1 bits.
- R3: While the captured enable is 1 and history is primed, `out_i` = `in_i` minus the I sample of the previous chirp at the same `in_bin`, and likewise for Q. The result is a DW+1-bit two's-complement value.
- R4: On the first chirp whose start-of-chirp sample captures enable = 1 while the previous chirp was not enabled, every valid output carries I = Q = 0.
- R5: `cancel_en` is captured only on a sample with `in_valid` = 1 and `in_sof` = 1. A change in the middle of a chirp has no effect until the next start-of-chirp.
- R6: `out_valid` and `out_bin` repeat `in_valid` and `in_bin` exactly 2 clock cycles later, and idle gaps in the input are kept.
- R7: Two identical consecutive chirps with the canceller enabled give all-zero outputs on the second chirp.
- R8: Full-scale differences do not wrap. With DW = 16, I going from 32767 to -32768 gives -65535, and Q going from -32768 to 32767 gives 65535.
- R9: Turning the canceller off for a chirp and then back on re-primes the history. The first re-enabled chirp outputs zeros and the next one outputs true differences.
- R10: History is addressed by `in_bin`, not by arrival order. A chirp that visits its bins in reverse order still subtracts the matching bin's previous sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cancel_en | input | 1 | Host enable for cancelling; captured at start-of-chirp |
| in_valid | input | 1 | Input sample valid |
| in_sof | input | 1 | Marks the first sample of a chirp (qualified by in_valid) |
| in_bin | input | BW | Range bin index of the input sample |
| in_i | input | DW | Input in-phase sample, signed |
| in_q | input | DW | Input quadrature sample, signed |
| out_valid | output | 1 | Output sample valid |
| out_bin | output | BW | Range bin index of the output sample |
| out_i | output | DW+1 | Output in-phase difference or pass-through, signed |
| out_q | output | DW+1 | Output quadrature difference or pass-through, signed |

## Verification
Every sample result is due exactly two rising edges after the sample is presented. One edge captures the sample together with the history read, and the second edge registers the selected result. The enable decision is made on the same edge that captures the start-of-chirp sample, so the whole chirp follows it. The bench drives each input on a falling edge and waits one rising edge. On the next falling edge it compares the outputs against the sample driven in the step before. This holds one expectation in flight at all times, and idle steps are compared as `out_valid` = 0 with the same alignment.

// File: rtl/mti_canceller.sv
module mti_canceller #(
  parameter int DW    = 16,
  parameter int NBINS = 64,
  localparam int BW   = (NBINS > 1) ? $clog2(NBINS) : 1,
  localparam int OW   = DW + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cancel_en,
  input  logic                 in_valid,
  input  logic                 in_sof,
  input  logic [BW-1:0]        in_bin,
  input  logic signed [DW-1:0] in_i,
  input  logic signed [DW-1:0] in_q,
  output logic                 out_valid,
  output logic [BW-1:0]        out_bin,
  output logic signed [OW-1:0] out_i,
  output logic signed [OW-1:0] out_q
);

  typedef enum logic [1:0] {M_PASS, M_ZERO, M_DIFF} mode_t;

  logic [2*DW-1:0] hist_mem [NBINS];

  logic en_q, prime_q;
  wire  boundary  = in_valid & in_sof;
  wire  en_now    = boundary ? cancel_en : en_q;
  wire  prime_now = boundary ? (cancel_en & en_q) : prime_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      prime_q <= 1'b0;
    end else if (boundary) begin
      en_q    <= cancel_en;
      prime_q <= cancel_en & en_q;
    end
  end

  logic                 v1;
  logic [BW-1:0]        bin1;
  logic signed [DW-1:0] cur_i1, cur_q1;
  mode_t                mode1;
  logic [2*DW-1:0]      old1;

  always_ff @(posedge clk) begin
    if (in_valid) begin
      old1             <= hist_mem[in_bin];
      hist_mem[in_bin] <= {in_i, in_q};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v1     <= 1'b0;
      bin1   <= '0;
      cur_i1 <= '0;
      cur_q1 <= '0;
      mode1  <= M_PASS;
    end else begin
      v1 <= in_valid;
      if (in_valid) begin
        bin1   <= in_bin;
        cur_i1 <= in_i;
        cur_q1 <= in_q;
        mode1  <= !en_now ? M_PASS : (!prime_now ? M_ZERO : M_DIFF);
      end
    end
  end

  wire signed [DW-1:0] old_i = old1[2*DW-1:DW];
  wire signed [DW-1:0] old_q = old1[DW-1:0];
  wire signed [OW-1:0] ext_i = {cur_i1[DW-1], cur_i1};
  wire signed [OW-1:0] ext_q = {cur_q1[DW-1], cur_q1};
  wire signed [OW-1:0] dif_i = ext_i - {old_i[DW-1], old_i};
  wire signed [OW-1:0] dif_q = ext_q - {old_q[DW-1], old_q};

  logic signed [OW-1:0] res_i, res_q;
  always_comb begin
    case (mode1)
      M_ZERO:  begin res_i = '0;    res_q = '0;    end
      M_DIFF:  begin res_i = dif_i; res_q = dif_q; end
      default: begin res_i = ext_i; res_q = ext_q; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_bin   <= '0;
      out_i     <= '0;
      out_q     <= '0;
    end else begin
      out_valid <= v1;
      if (v1) begin
        out_bin <= bin1;
        out_i   <= res_i;
        out_q   <= res_q;
      end
    end
  end

  AST_EN_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n) !boundary |=> $stable(en_q)); // R5
  AST_PRIME_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n) prime_q |-> en_q); // R4
  AST_VALID_PIPE: assert property (@(posedge clk) disable iff (!rst_n) v1 |=> out_valid); // R6
  AST_IDLE_PIPE: assert property (@(posedge clk) disable iff (!rst_n) !v1 |=> !out_valid); // R6
  AST_BIN_PIPE: assert property (@(posedge clk) disable iff (!rst_n) v1 |=> out_bin == $past(bin1)); // R6
  AST_ZERO_FIRST: assert property (@(posedge clk) disable iff (!rst_n) (v1 && mode1 == M_ZERO) |=> (out_i == '0 && out_q == '0)); // R4
  AST_PASS_EXACT: assert property (@(posedge clk) disable iff (!rst_n) (v1 && mode1 == M_PASS) |=> (out_i[DW-1:0] == $past(cur_i1) && out_i[DW] == out_i[DW-1] && out_q[DW-1:0] == $past(cur_q1) && out_q[DW] == out_q[DW-1])); // R2

endmodule

// File: tb/mti_canceller_tb.sv
module mti_canceller_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DW    = 16;
  localparam int NBINS = 64;
  localparam int BW    = $clog2(NBINS);
  localparam int OW    = DW + 1;
  localparam int NB    = 8;

  logic clk, rst_n, cancel_en, in_valid, in_sof;
  logic [BW-1:0] in_bin;
  logic signed [DW-1:0] in_i, in_q;
  logic out_valid;
  logic [BW-1:0] out_bin;
  logic signed [OW-1:0] out_i, out_q;

  mti_canceller #(.DW(DW), .NBINS(NBINS)) u_dut (
    .clk(clk), .rst_n(rst_n), .cancel_en(cancel_en),
    .in_valid(in_valid), .in_sof(in_sof), .in_bin(in_bin), .in_i(in_i), .in_q(in_q),
    .out_valid(out_valid), .out_bin(out_bin), .out_i(out_i), .out_q(out_q)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int n_cmp = 0, n_bad = 0;

  bit en_m, prime_m;
  logic [DW-1:0] hi [NBINS];
  logic [DW-1:0] hq [NBINS];

  bit have_pend;
  bit pv;
  logic [BW-1:0] pbin;
  logic signed [OW-1:0] pi, pq;
  string ptag;

  task automatic check_pending();
    bit bad;
    if (!have_pend) return;
    n_cmp++;
    bad = (out_valid !== pv);
    if (pv && !bad) bad = (out_bin !== pbin) || (out_i !== pi) || (out_q !== pq);
    if (bad) begin
      n_bad++;
      $display("FAIL %s: got valid=%0b bin=%0d i=%0d q=%0d, expected valid=%0b bin=%0d i=%0d q=%0d",
               ptag, out_valid, out_bin, out_i, out_q, pv, pbin, pi, pq);
    end
  endtask

  task automatic step(input bit v, input bit sof, input int bin, input int si, input int sq, input string tag);
    logic [DW-1:0] ci, cq;
    in_valid = v; in_sof = sof; in_bin = BW'(bin);
    in_i = DW'(si); in_q = DW'(sq);
    ci = DW'(si); cq = DW'(sq);
    if (v && sof) begin
      prime_m = cancel_en && en_m;
      en_m    = cancel_en;
    end
    @(posedge clk);
    @(negedge clk);
    check_pending();
    have_pend = 1'b1;
    pv = v; pbin = BW'(bin); ptag = tag;
    if (v) begin
      if (!en_m) begin
        pi = {ci[DW-1], ci}; pq = {cq[DW-1], cq};
      end else if (!prime_m) begin
        pi = '0; pq = '0;
      end else begin
        pi = $signed({ci[DW-1], ci}) - $signed({hi[bin][DW-1], hi[bin]});
        pq = $signed({cq[DW-1], cq}) - $signed({hq[bin][DW-1], hq[bin]});
      end
      hi[bin] = ci; hq[bin] = cq;
    end
  endtask

  task automatic idle(input int n, input string tag);
    for (int k = 0; k < n; k++) step(1'b0, 1'b0, 0, 0, 0, tag);
  endtask

  function automatic int vi(input int seed, input int bin);
    return seed * 211 + bin * 1013 - 5000;
  endfunction
  function automatic int vq(input int seed, input int bin);
    return 3000 - seed * 97 - bin * 389;
  endfunction

  task automatic chirp(input int seed, input bit rev, input int flip_at, input bit gaps, input string tag);
    for (int k = 0; k < NB; k++) begin
      int b;
      b = rev ? NB - 1 - k : k;
      if (k == flip_at) cancel_en = ~cancel_en;
      step(1'b1, k == 0, b, vi(seed, b), vq(seed, b), tag);
      if (gaps && (k % 3 == 2)) step(1'b0, 1'b0, 0, 0, 0, tag);
    end
  endtask

  task automatic chirp_const(input int ci, input int cq, input string tag);
    for (int k = 0; k < NB; k++) step(1'b1, k == 0, k, ci, cq, tag);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; cancel_en = 1'b0; in_valid = 1'b0; in_sof = 1'b0;
    in_bin = '0; in_i = '0; in_q = '0;
    en_m = 1'b0; prime_m = 1'b0; have_pend = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    n_cmp++;
    if (out_valid !== 1'b0 || out_i !== '0 || out_q !== '0 || out_bin !== '0) begin
      n_bad++;
      $display("FAIL R1: got valid=%0b bin=%0d i=%0d q=%0d, expected all zero", out_valid, out_bin, out_i, out_q);
    end
    cancel_en = 1'b1;
    step(1'b1, 1'b0, 5, -1234, 4321, "R1");
    idle(2, "R1");
  endtask

  task automatic t_bypass();
    cancel_en = 1'b0;
    chirp(1, 1'b0, -1, 1'b1, "R2");
    chirp(2, 1'b0, -1, 1'b0, "R6");
    idle(2, "R6");
  endtask

  task automatic t_prime();
    cancel_en = 1'b1;
    chirp(3, 1'b0, -1, 1'b0, "R4");
  endtask

  task automatic t_diff();
    chirp(4, 1'b0, -1, 1'b1, "R3");
    chirp(9, 1'b1, -1, 1'b0, "R10");
  endtask

  task automatic t_static();
    chirp(6, 1'b0, -1, 1'b0, "R3");
    chirp(6, 1'b0, -1, 1'b0, "R7");
  endtask

  task automatic t_extreme();
    chirp_const(32767, -32768, "R8");
    chirp_const(-32768, 32767, "R8");
  endtask

  task automatic t_midchange();
    chirp(11, 1'b0, 3, 1'b0, "R5");
    chirp(12, 1'b0, 4, 1'b0, "R5");
  endtask

  task automatic t_reenable();
    chirp(13, 1'b0, -1, 1'b0, "R9");
    chirp(14, 1'b1, -1, 1'b0, "R9");
    idle(3, "R9");
  endtask

  initial begin
    t_reset();
    t_bypass();
    t_prime();
    t_diff();
    t_static();
    t_extreme();
    t_midchange();
    t_reenable();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule